// File: doc/BRIEF.md
# Accumulator Overflow Trap Logic

This block sits beside the two signed DSP accumulators, A and B, and watches every result written into them. For each accumulator it keeps a read-only overflow status flag. The flag records whether the last value written has spilled into the guard bits above the normal signed range. The block also catches the catastrophic case, a carry out of the most significant accumulator bit. In that case the sign of the result can no longer be trusted, so the block sets a sticky math-error flag and raises a trap request.

The trap is armed per accumulator. Catastrophic-overflow trapping must be enabled, and saturation must be off for that accumulator. Software cannot write the overflow status flags. A later write to the accumulator recomputes them, and a write of zero always clears them. If the trap handler clears the math-error flag while an armed accumulator still holds its catastrophic condition, the clear does not take effect and the trap request stays asserted. The handler is therefore entered again. Handler code has to overwrite the accumulator before it clears the flag.

Top module: `acc_ovf_trap`

## Requirements
- R1: While reset is held and after it is released, ovf_a, ovf_b, math_err and trap_req are all 0 until the first write.
- R2: On a write (wr_en=1, wr_sel=0 selects A, wr_sel=1 selects B), the selected accumulator's overflow flag becomes 1 on the next clock edge. It becomes 1 exactly when the top GUARD_W+1 bits of wr_data are not all equal, that is, when the signed result lies outside the range of an (ACC_W-GUARD_W)-bit signed number. The other accumulator's flag keeps its value.
- R3: A write of zero to an accumulator clears that accumulator's overflow flag and its latched catastrophic condition, even when wr_carry is 1. Such a write does not set math_err.
- R4: A write with wr_carry=1 and a nonzero result sets math_err on the next edge and drives trap_req high. The write must be to an accumulator that is armed, meaning trap_en=1 and that accumulator's saturation enable is 0.
- R5: A carry-out write leaves math_err at 0 if trap_en=0 or if saturation is enabled for the written accumulator.
- R6: Once set, math_err stays 1 until it is cleared by a clear strobe that takes effect.
- R7: A one-cycle clr_math_err pulse clears math_err on the next edge when no armed accumulator has a catastrophic condition latched. Otherwise math_err stays 1 and trap_req stays high, so the trap re-enters.
- R8: When a new catastrophic write and clr_math_err occur in the same cycle, math_err ends up 1.
- R9: trap_req is 1 only while math_err is 1 and an armed accumulator has its catastrophic condition latched. A later write without carry to that accumulator drops trap_req on the next edge and leaves math_err set.
- R10: While wr_en is 0, the values on wr_data, wr_carry and wr_sel do not change either overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Accumulator write strobe |
| wr_sel | input | 1 | Written accumulator: 0 = A, 1 = B |
| wr_data | input | ACC_W | Result written to the accumulator |
| wr_carry | input | 1 | Carry out of the top accumulator bit for this result |
| trap_en | input | 1 | Catastrophic-overflow trap enable |
| sat_en_a | input | 1 | Saturation enabled for accumulator A |
| sat_en_b | input | 1 | Saturation enabled for accumulator B |
| clr_math_err | input | 1 | Single-cycle software clear of the math-error flag |
| ovf_a | output | 1 | Overflow status of accumulator A (read-only) |
| ovf_b | output | 1 | Overflow status of accumulator B (read-only) |
| math_err | output | 1 | Sticky math-error flag |
| trap_req | output | 1 | Math-error trap request |

## Verification
The bench builds the block with ACC_W=12 and GUARD_W=3, which shrinks an accumulator to 4096 values. At that size every possible result can be written to both A and B. The expected overflow flag for each result is worked out from its signed value against the range -256..255. Directed sequences then cover arming, saturation masking, a clear during a pending trap that forces re-entry, a set and a clear in the same cycle, and zero writes that carry a carry-out.

// File: rtl/acc_ovf_trap.sv
module acc_ovf_trap #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             wr_carry,
  input  logic             trap_en,
  input  logic             sat_en_a,
  input  logic             sat_en_b,
  input  logic             clr_math_err,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             math_err,
  output logic             trap_req
);
  localparam int TOP_W = GUARD_W + 1;

  logic [TOP_W-1:0] top;
  logic res_ovf, res_zero, wr_a, wr_b, armed_a, armed_b, hit, pending;
  logic cat_a, cat_b;

  assign top      = wr_data[ACC_W-1 -: TOP_W];
  assign res_ovf  = ~(&top) & (|top);
  assign res_zero = ~|wr_data;
  assign wr_a     = wr_en & ~wr_sel;
  assign wr_b     = wr_en &  wr_sel;
  assign armed_a  = trap_en & ~sat_en_a;
  assign armed_b  = trap_en & ~sat_en_b;
  assign hit      = ((wr_a & armed_a) | (wr_b & armed_b)) & wr_carry & ~res_zero;
  assign pending  = (cat_a & armed_a) | (cat_b & armed_b);
  assign trap_req = math_err & pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_a    <= 1'b0;
      ovf_b    <= 1'b0;
      cat_a    <= 1'b0;
      cat_b    <= 1'b0;
      math_err <= 1'b0;
    end else begin
      if (wr_a) begin
        ovf_a <= res_ovf;
        cat_a <= wr_carry & ~res_zero;
      end
      if (wr_b) begin
        ovf_b <= res_ovf;
        cat_b <= wr_carry & ~res_zero;
      end
      if (hit)
        math_err <= 1'b1;
      else if (clr_math_err && !pending)
        math_err <= 1'b0;
    end
  end
endmodule

module acc_ovf_trap_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [ACC_W-1:0] wr_data,
  input logic             wr_carry,
  input logic             trap_en,
  input logic             sat_en_a,
  input logic             sat_en_b,
  input logic             clr_math_err,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             math_err,
  input logic             trap_req
);
  logic event_c;
  assign event_c = wr_en && wr_carry && (wr_data != '0) && trap_en &&
                   !(wr_sel ? sat_en_b : sat_en_a);

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ovf_a) && $stable(ovf_b));

  p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_data == '0) |=> (wr_sel ? !ovf_b : !ovf_a));

  p_other_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> $stable(ovf_b));

  p_trap_needs_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> math_err);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    event_c |=> math_err);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    math_err && !clr_math_err |=> math_err);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !math_err && !event_c |=> !math_err);
endmodule

bind acc_ovf_trap acc_ovf_trap_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wr_carry(wr_carry), .trap_en(trap_en), .sat_en_a(sat_en_a), .sat_en_b(sat_en_b),
  .clr_math_err(clr_math_err), .ovf_a(ovf_a), .ovf_b(ovf_b), .math_err(math_err),
  .trap_req(trap_req)
);

// File: tb/test_acc_ovf_trap.sv
module test_acc_ovf_trap;
  localparam int W = 12;
  localparam int G = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, wr_carry = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic trap_en = 1'b0, sat_en_a = 1'b0, sat_en_b = 1'b0, clr_math_err = 1'b0;
  logic ovf_a, ovf_b, math_err, trap_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_ovf_trap #(.ACC_W(W), .GUARD_W(G)) i_acc_ovf_trap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_carry(wr_carry), .trap_en(trap_en), .sat_en_a(sat_en_a), .sat_en_b(sat_en_b),
    .clr_math_err(clr_math_err), .ovf_a(ovf_a), .ovf_b(ovf_b), .math_err(math_err),
    .trap_req(trap_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic sel, input int data, input logic carry, input logic clr);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(data); wr_carry = carry; clr_math_err = clr;
    @(negedge clk);
    wr_en = 1'b0; wr_carry = 1'b0; clr_math_err = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr_math_err = 1'b1;
    @(negedge clk);
    clr_math_err = 1'b0;
  endtask

  function automatic logic exp_ovf(input int v);
    int s;
    s = (v >= (1 << (W-1))) ? v - (1 << W) : v;
    return (s < -(1 << (W-G-1))) || (s > (1 << (W-G-1)) - 1);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ovf_a", ovf_a, 1'b0); chk("R1 ovf_b", ovf_b, 1'b0);
    chk("R1 math_err", math_err, 1'b0); chk("R1 trap_req", trap_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", ovf_a | ovf_b | math_err | trap_req, 1'b0);

    // R2: exhaustive sweep of both accumulators
    for (int sel = 0; sel < 2; sel++) begin
      for (int v = 0; v < (1 << W); v++) begin
        logic other;
        other = sel ? ovf_a : ovf_b;
        wr(sel[0], v, 1'b0, 1'b0);
        chk("R2 selected flag", sel ? ovf_b : ovf_a, exp_ovf(v));
        chk("R2 other flag", sel ? ovf_a : ovf_b, other);
      end
    end
    chk("R5 no trap without carry", math_err, 1'b0);

    // R3: zero write clears an overflow flag
    wr(1'b0, 'h900, 1'b0, 1'b0);
    chk("R3 precondition", ovf_a, 1'b1);
    wr(1'b0, 0, 1'b0, 1'b0);
    chk("R3 zero clears ovf_a", ovf_a, 1'b0);

    // R10: flags ignore the write bus while wr_en is low
    wr(1'b1, 'h700, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      wr_sel = i[0]; wr_data = W'(i * 97); wr_carry = i[1];
      @(negedge clk);
      chk("R10 ovf_a held", ovf_a, 1'b0);
      chk("R10 ovf_b held", ovf_b, 1'b1);
    end
    wr_carry = 1'b0;

    // R5: carry without arming
    trap_en = 1'b0;
    wr(1'b0, 'h900, 1'b1, 1'b0);
    chk("R5 trap_en=0", math_err, 1'b0);
    trap_en = 1'b1; sat_en_a = 1'b1;
    wr(1'b0, 'h900, 1'b1, 1'b0);
    chk("R5 sat A", math_err, 1'b0);
    chk("R5 sat A trap_req", trap_req, 1'b0);
    sat_en_a = 1'b0; sat_en_b = 1'b1;
    wr(1'b1, 'h900, 1'b1, 1'b0);
    chk("R5 sat B", math_err, 1'b0);
    sat_en_b = 1'b0;
    wr(1'b0, 'h010, 1'b0, 1'b0);
    wr(1'b1, 'h010, 1'b0, 1'b0);

    // R4: catastrophic overflow on A
    wr(1'b0, 'h900, 1'b1, 1'b0);
    chk("R4 math_err", math_err, 1'b1);
    chk("R4 trap_req", trap_req, 1'b1);
    chk("R4 ovf_a", ovf_a, 1'b1);

    // R6: sticky over idle cycles
    repeat (5) @(negedge clk);
    chk("R6 math_err sticky", math_err, 1'b1);

    // R7: clear while pending re-enters
    pulse_clr();
    chk("R7 clear while pending math_err", math_err, 1'b1);
    chk("R7 clear while pending trap_req", trap_req, 1'b1);

    // R9: non-carry write drops request, math_err remains
    wr(1'b0, 'h010, 1'b0, 1'b0);
    chk("R9 trap_req drops", trap_req, 1'b0);
    chk("R9 math_err kept", math_err, 1'b1);
    chk("R9 ovf_a cleared", ovf_a, 1'b0);

    // R7: clear with nothing pending
    pulse_clr();
    chk("R7 clear takes effect", math_err, 1'b0);

    // R8: set and clear in the same cycle on B
    wr(1'b1, 'h600, 1'b1, 1'b1);
    chk("R8 set wins", math_err, 1'b1);
    chk("R8 trap_req", trap_req, 1'b1);

    // R3: zero write with carry clears the latched condition
    wr(1'b1, 0, 1'b1, 1'b0);
    chk("R3 zero clears trap_req", trap_req, 1'b0);
    chk("R3 zero clears ovf_b", ovf_b, 1'b0);
    pulse_clr();
    chk("R3 zero write sets nothing", math_err, 1'b0);
    wr(1'b0, 0, 1'b1, 1'b0);
    chk("R3 zero carry no set", math_err, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule